// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block receives configuration words over a three-wire serial bus made of a serial clock, a data line and an enable line. All three lines are sampled by the system clock through synchronizer flops. While enable is high, each rising edge of the serial clock shifts one data bit into a 20-bit shift register, most significant bit first. When enable drops, the three most recently received bits are decoded as an address. The 17 bits received before them are written into the holding register that the address selects.

Six holding registers are decoded:

| Address | Register |
|---|---|
| 1 | Channel 1 main/swallow |
| 2 | Channel 1 reference |
| 3 | Channel 2 main/swallow |
| 4 | Channel 2 reference |
| 5 | Auxiliary control |
| 6 | Main control |

For the two main/swallow registers, the block splits the stored word into an 11-bit main count and a 6-bit swallow count. The other four registers are presented as full 17-bit words.

Each register has its own one-cycle write strobe, so downstream divider logic knows when to take a new value. The loader counts no bits and has no gating input. It therefore stays programmable while the rest of the chip is powered down.

Top module: `cfg3w_loader`

## Requirements
- R1: After reset, every holding register reads zero and every write strobe is low.
- R2: While enable is high, one data bit is taken on each rising serial clock edge, most significant first. In a 20-bit frame, the first 17 bits are the data word and the last 3 bits are the address.
- R3: A register is written only after enable falls. No write occurs while enable stays high.
- R4: Addresses 1 to 6 write channel 1 main/swallow, channel 1 reference, channel 2 main/swallow, channel 2 reference, auxiliary control and main control, in that order. For the main/swallow registers, data bits 16..6 give the main count and bits 5..0 give the swallow count.
- R5: Addresses 0 and 7 write nothing, and every register keeps its value.
- R6: When more than 20 bits arrive, the leading extra bits are dropped and only the last 20 are used.
- R7: When fewer than 20 bits arrive, the shift register, cleared when enable rises, is zero-filled above the received bits, and that word is still decoded and written.
- R8: Strobe bit k-1 pulses high for exactly one system clock when address k is written. The new value appears on the outputs in that same cycle, the third system clock edge after enable falls at the pin. At most one strobe is high at a time.
- R9: Serial clock and data activity while enable is low changes no register and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk_i | input | 1 | Serial bus clock |
| bus_dat_i | input | 1 | Serial bus data |
| bus_en_i | input | 1 | Serial bus enable |
| ch1_main_o | output | 11 | Channel 1 main count |
| ch1_swal_o | output | 6 | Channel 1 swallow count |
| ch1_ref_o | output | 17 | Channel 1 reference word |
| ch2_main_o | output | 11 | Channel 2 main count |
| ch2_swal_o | output | 6 | Channel 2 swallow count |
| ch2_ref_o | output | 17 | Channel 2 reference word |
| aux_ctl_o | output | 17 | Auxiliary control word |
| main_ctl_o | output | 17 | Main control word |
| wr_stb_o | output | 6 | One-cycle write strobe per register |

## Verification
Faults in the shift register or the edge detectors show up as a wrong value in whichever register the next frame addresses. They appear on the same cycle as that register's strobe, three system clocks after enable falls. A decoder fault shows up at that same strobe as the wrong strobe bit or a spurious one. A fault in the holding-register enables shows up as a register changing without its strobe. A comparison of all six registers at the end of every frame catches it within that frame. Frames that are long, short, use an unused address, or have clocking while enable is low each target a separate piece of that state.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;
  localparam int FRAME_W = 20;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = FRAME_W - ADDR_W;
  localparam int SWAL_W  = 6;
  localparam int MAIN_W  = DATA_W - SWAL_W;
  localparam int NSLOT   = 6;

  // Address k (1..NSLOT) selects slot k-1; other codes select nothing.
  function automatic logic [NSLOT-1:0] slot_sel(input logic [ADDR_W-1:0] a);
    logic [NSLOT-1:0] s;
    s = '0;
    for (int k = 1; k <= NSLOT; k++) begin
      if (int'(a) == k) s[k-1] = 1'b1;
    end
    return s;
  endfunction
endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfg3w_shift.sv
module cfg3w_shift #(
  parameter int FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s_clk,
  input  logic               s_dat,
  input  logic               s_en,
  output logic               load_o,
  output logic [FRAME_W-1:0] word_o
);
  logic               clk_q, en_q;
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic               clk_rise, en_rise, en_fall;

  always_comb begin
    clk_rise = s_clk & ~clk_q;
    en_rise  = s_en & ~en_q;
    en_fall  = ~s_en & en_q;
    sr_d     = sr_q;
    if (en_rise) sr_d = '0;
    else if (s_en && clk_rise) sr_d = {sr_q[FRAME_W-2:0], s_dat};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= 1'b0;
      en_q  <= 1'b0;
      sr_q  <= '0;
    end else begin
      clk_q <= s_clk;
      en_q  <= s_en;
      sr_q  <= sr_d;
    end
  end

  assign load_o = en_fall;
  assign word_o = sr_q;

  // R9: with enable low the shift register does not move
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_en && !en_q) |=> $stable(sr_q));

  // R2: a serial rising edge inside a frame appends the sampled data bit
  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_en && en_q && s_clk && !clk_q) |=> (sr_q[0] == $past(s_dat)));
endmodule

// File: rtl/cfg3w_regbank.sv
module cfg3w_regbank
  import cfg3w_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load_i,
  input  logic [FRAME_W-1:0]           word_i,
  output logic [NSLOT-1:0][DATA_W-1:0] q_o,
  output logic [NSLOT-1:0]             stb_o
);
  logic [NSLOT-1:0] sel;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;

  always_comb begin
    addr = word_i[ADDR_W-1:0];
    data = word_i[FRAME_W-1:ADDR_W];
    sel  = load_i ? slot_sel(addr) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_o <= '0;
    else        stb_o <= sel;
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o[k] <= '0;
      else if (sel[k]) q_o[k] <= data;
    end

    // R5: a register only changes together with its own strobe
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_o[k] |-> $stable(q_o[k]));

    // R8: each strobe is a single-cycle pulse
    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stb_o[k] |=> !stb_o[k]);
  end

  // R8: never more than one strobe at a time
  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb_o));

  // R3: a strobe follows a load pulse from the shift stage
  p_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|stb_o) |-> $past(load_i));

  // R5: unused addresses raise no strobe
  p_unused_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && (word_i[ADDR_W-1:0] == '0 || word_i[ADDR_W-1:0] == '1))
      |=> (stb_o == '0));
endmodule

// File: rtl/cfg3w_loader.sv
module cfg3w_loader
  import cfg3w_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_clk_i,
  input  logic              bus_dat_i,
  input  logic              bus_en_i,
  output logic [MAIN_W-1:0] ch1_main_o,
  output logic [SWAL_W-1:0] ch1_swal_o,
  output logic [DATA_W-1:0] ch1_ref_o,
  output logic [MAIN_W-1:0] ch2_main_o,
  output logic [SWAL_W-1:0] ch2_swal_o,
  output logic [DATA_W-1:0] ch2_ref_o,
  output logic [DATA_W-1:0] aux_ctl_o,
  output logic [DATA_W-1:0] main_ctl_o,
  output logic [NSLOT-1:0]  wr_stb_o
);
  localparam int LINES = 3;

  logic [1:0]               rst_sync_q;
  logic                     rst_int_n;
  logic [LINES-1:0]         line_s;
  logic                     load;
  logic [FRAME_W-1:0]       word;
  logic [NSLOT-1:0][DATA_W-1:0] regs;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cfg3w_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   ({bus_en_i, bus_dat_i, bus_clk_i}),
    .q_o   (line_s)
  );

  cfg3w_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .s_clk  (line_s[0]),
    .s_dat  (line_s[1]),
    .s_en   (line_s[2]),
    .load_o (load),
    .word_o (word)
  );

  cfg3w_regbank u_bank (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (load),
    .word_i (word),
    .q_o    (regs),
    .stb_o  (wr_stb_o)
  );

  assign {ch1_main_o, ch1_swal_o} = regs[0];
  assign ch1_ref_o                = regs[1];
  assign {ch2_main_o, ch2_swal_o} = regs[2];
  assign ch2_ref_o                = regs[3];
  assign aux_ctl_o                = regs[4];
  assign main_ctl_o               = regs[5];
endmodule

// File: tb/cfg3w_loader_test.sv
module cfg3w_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, bdat = 1'b0, ben = 1'b0;
  logic [10:0] ch1_main, ch2_main;
  logic [5:0]  ch1_swal, ch2_swal;
  logic [16:0] ch1_ref, ch2_ref, aux_ctl, main_ctl;
  logic [5:0]  wr_stb;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  logic [5:0]  prev_stb = '0;
  logic [19:0] exp_q[$];
  logic [16:0] shadow [6];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg3w_loader uut (
    .clk(clk), .rst_n(rst_n),
    .bus_clk_i(bclk), .bus_dat_i(bdat), .bus_en_i(ben),
    .ch1_main_o(ch1_main), .ch1_swal_o(ch1_swal), .ch1_ref_o(ch1_ref),
    .ch2_main_o(ch2_main), .ch2_swal_o(ch2_swal), .ch2_ref_o(ch2_ref),
    .aux_ctl_o(aux_ctl), .main_ctl_o(main_ctl), .wr_stb_o(wr_stb)
  );

  function automatic logic [16:0] out_val(input int slot);
    case (slot)
      0: return {ch1_main, ch1_swal};
      1: return ch1_ref;
      2: return {ch2_main, ch2_swal};
      3: return ch2_ref;
      4: return aux_ctl;
      default: return main_ctl;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // monitor: pops expected writes as strobes appear
  always @(negedge clk) begin
    if (mon_on) begin
      if (wr_stb != '0) begin
        chk($onehot(wr_stb), "R8", "single strobe", 32'(wr_stb), 32'd1);
        chk((wr_stb & prev_stb) == '0, "R8", "strobe width", 32'(prev_stb), 32'd0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected strobe", 32'(wr_stb), 32'd0);
        end else begin
          logic [19:0] e;
          int slot;
          e = exp_q.pop_front();
          slot = int'(e[19:17]);
          chk(wr_stb == 6'(1 << slot), "R4", "strobe slot", 32'(wr_stb), 32'(1 << slot));
          chk(out_val(slot) == e[16:0], "R2", "written value", 32'(out_val(slot)), 32'(e[16:0]));
        end
      end
      prev_stb = wr_stb;
    end
  end

  // driver: sends n bits MSB first, models the shift register, pushes expectation
  task automatic send_bits(input logic [63:0] bits, input int n);
    logic [19:0] sr;
    int a;
    sr = '0;
    @(negedge clk); ben = 1'b1; bclk = 1'b0;
    repeat (HOLD) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      bdat = bits[i];
      repeat (HOLD) @(negedge clk);
      bclk = 1'b1;
      repeat (HOLD) @(negedge clk);
      bclk = 1'b0;
      sr = {sr[18:0], bits[i]};
    end
    repeat (HOLD) @(negedge clk);
    chk(exp_q.size() == 0 && wr_stb == '0, "R3", "no write while enable high",
        32'(wr_stb), 32'd0);
    a = int'(sr[2:0]);
    if (a >= 1 && a <= 6) begin
      exp_q.push_back({3'(a - 1), sr[19:3]});
      shadow[a-1] = sr[19:3];
    end
    ben = 1'b0;
    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "write seen within window", 32'(exp_q.size()), 32'd0);
    for (int k = 0; k < 6; k++)
      chk(out_val(k) == shadow[k], "R5", "register contents", 32'(out_val(k)), 32'(shadow[k]));
  endtask

  task automatic frame(input logic [2:0] addr, input logic [16:0] data);
    send_bits(64'({data, addr}), 20);
  endtask

  initial begin
    for (int k = 0; k < 6; k++) shadow[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    for (int k = 0; k < 6; k++)
      chk(out_val(k) == '0, "R1", "reset value", 32'(out_val(k)), 32'd0);
    chk(wr_stb == '0, "R1", "reset strobes", 32'(wr_stb), 32'd0);
    mon_on = 1'b1;

    // R4: every address, main/swallow split
    frame(3'd1, {11'h5A3, 6'h2C});
    chk({ch1_main, ch1_swal} == {11'h5A3, 6'h2C}, "R4", "ch1 main/swallow split",
        32'({ch1_main, ch1_swal}), 32'({11'h5A3, 6'h2C}));
    frame(3'd2, 17'h00ABC);
    frame(3'd3, {11'h7FF, 6'h3F});
    chk(ch2_main == 11'h7FF && ch2_swal == 6'h3F, "R4", "ch2 all ones",
        32'({ch2_main, ch2_swal}), 32'h1FFFF);
    frame(3'd4, 17'h10001);
    frame(3'd5, 17'h0F0F0);
    frame(3'd6, 17'h15555);
    // R5: unused addresses
    frame(3'd0, 17'h1FFFF);
    frame(3'd7, 17'h0AAAA);
    // R6: 5 extra leading bits, then a full frame to address 2
    send_bits({39'd0, 5'b10111, 17'h13579, 3'd2}, 25);
    // R7: short frame of 8 bits -> address 5, data 5'b10110 zero-extended
    send_bits(64'b1011_0101, 8);
    chk(aux_ctl == 17'h00016, "R7", "short frame zero fill", 32'(aux_ctl), 32'h16);
    // R7: 3-bit frame -> address 1, data zero
    send_bits(64'b001, 3);
    // R9: serial activity with enable low
    for (int i = 0; i < 10; i++) begin
      bdat = i[0];
      repeat (HOLD) @(negedge clk);
      bclk = ~bclk;
    end
    bclk = 1'b0;
    repeat (10) @(negedge clk);
    for (int k = 0; k < 6; k++)
      chk(out_val(k) == shadow[k], "R9", "no change with enable low",
          32'(out_val(k)), 32'(shadow[k]));
    // R2: overwrite after idle traffic
    frame(3'd6, 17'h00001);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "run timed out", 32'd0, 32'd1);
    finish_run();
  end
endmodule